// File: doc/BRIEF.md
# Radio Transmit Start Sequencer

This block is the control state machine that launches a packet transmission in a low-rate wireless transceiver. It tracks an idle state (off, synthesizer locked, or auto-retry transmit ready) that a command field sets. It accepts a transmit trigger from one of two sources: a rising edge on a transmit pin bit, or a start code written to the command field. A trigger is taken only while the synthesizer is locked or the auto-retry transmitter is ready.

On an accepted trigger the block reports a busy-transmit state. It then enables the PA buffer, enables the PA a fixed number of cycles later, and gives the modulator a one-cycle start strobe at a fixed delay after the trigger. When the modulator signals the end of the frame, the block powers down the PA and then the PA buffer, and returns to the idle state it came from.

The frame buffer must already hold the whole frame when the trigger arrives. The modulator, the frame buffer and the analog front end appear only as handshake signals. A registered output-power level is passed to the PA control. It is held constant for the whole transmission.

Top module: `txstart_seq`

## Requirements
- R1: After a synchronous reset, `state_code` is 0 (off), and `pa_buf_en`, `pa_en`, `mod_start` and `trig_err` are all 0.
- R2: When the block is not busy, a `cmd_wr` strobe with `cmd_code` 8, 9 or 25 sets the state on the next edge to off, locked or retry-ready. The `state_code` values are 0 for off, 1 for locked, 2 for retry-ready and 3 for busy-transmit.
- R3: A 0-to-1 transition of `slp_tx_pin` while the state is locked or retry-ready starts a transmission. `state_code` becomes 3 on the edge that samples the high level. Holding the pin high does not start a second transmission.
- R4: A `cmd_wr` strobe with `cmd_code` 2 (start) starts a transmission with the same timing as R3.
- R5: `pa_buf_en` rises on the same edge that sets the busy state. `pa_en` rises PA_DLY cycles later. The two never rise together, and `pa_en` is never high without `pa_buf_en`.
- R6: `mod_start` is high for exactly one cycle, MOD_DLY cycles after `pa_buf_en` rises.
- R7: A trigger while the state is off, or while busy, changes no state and no enable. It sets `trig_err`, which stays set until reset.
- R8: When `frame_done` is high after `mod_start` has fired, `pa_en` falls on the next edge. One edge later `pa_buf_en` falls and `state_code` returns to the state the transmission started from.
- R9: While not busy, `pa_pwr` takes `pwr_in` on each edge. While busy, `pa_pwr` holds the value it had when the trigger was accepted.
- R10: A `frame_done` pulse before `mod_start` has fired has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_tx_pin | input | 1 | Transmit pin bit; a rising edge is a trigger |
| cmd_wr | input | 1 | Command field write strobe |
| cmd_code | input | CMD_W | Command code (2 start, 8 off, 9 locked, 25 retry-ready) |
| pwr_in | input | PWR_W | Output-power setting |
| frame_done | input | 1 | End-of-frame from the modulator |
| state_code | output | 2 | Encoded state |
| pa_buf_en | output | 1 | PA buffer enable |
| pa_en | output | 1 | PA enable |
| mod_start | output | 1 | One-cycle modulator start strobe |
| trig_err | output | 1 | Sticky flag for an ignored trigger |
| pa_pwr | output | PWR_W | Power level driven to the PA control |

## Verification
The bench checks that each enable edge lands on its exact cycle. An off-by-one counter would move the PA enable or the modulator strobe by one cycle, and a wrong shutdown order would drop both enables together. It holds the pin high through a whole transmission to catch level-triggered restarts. It pulses the frame end during the ramp to catch a design that cuts the PA before modulation has begun. It fires triggers while off and while busy, and expects no output activity but a set error flag. It also changes the power input mid-transmission to catch a PA level that is not frozen.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PLL  = 2'd1,
    ST_ARET = 2'd2,
    ST_BUSY = 2'd3
  } txs_state_e;

  typedef enum logic [1:0] {
    PH_RAMP = 2'd0,
    PH_RUN  = 2'd1,
    PH_DOWN = 2'd2
  } txs_phase_e;

  localparam int CMD_START = 2;
  localparam int CMD_OFF   = 8;
  localparam int CMD_PLL   = 9;
  localparam int CMD_ARET  = 25;
endpackage

// File: rtl/txs_trig_detect.sv
module txs_trig_detect #(
  parameter int CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             trig,
  output logic             go_off,
  output logic             go_pll,
  output logic             go_aret
);
  import txs_pkg::*;

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  always_comb begin
    trig    = (pin && !pin_q) || (cmd_wr && cmd_code == CMD_W'(CMD_START));
    go_off  = cmd_wr && cmd_code == CMD_W'(CMD_OFF);
    go_pll  = cmd_wr && cmd_code == CMD_W'(CMD_PLL);
    go_aret = cmd_wr && cmd_code == CMD_W'(CMD_ARET);
  end
endmodule

// File: rtl/txs_ramp_timer.sv
module txs_ramp_timer #(
  parameter int PA_DLY  = 128,
  parameter int MOD_DLY = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pa_hit,
  output logic mod_hit
);
  localparam int CNT_W = $clog2(MOD_DLY + 1);
  localparam logic [CNT_W-1:0] PA_LAST  = CNT_W'(PA_DLY - 1);
  localparam logic [CNT_W-1:0] MOD_LAST = CNT_W'(MOD_DLY - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt == MOD_LAST) active <= 1'b0;
    end
  end

  assign pa_hit  = active && (cnt == PA_LAST);
  assign mod_hit = active && (cnt == MOD_LAST);

  p_mod_once_r6: assert property (@(posedge clk) disable iff (rst)
    mod_hit |=> !mod_hit);
endmodule

// File: rtl/txstart_seq.sv
module txstart_seq #(
  parameter int PA_DLY  = 128,
  parameter int MOD_DLY = 256,
  parameter int PWR_W   = 4,
  parameter int CMD_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slp_tx_pin,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [PWR_W-1:0] pwr_in,
  input  logic             frame_done,
  output logic [1:0]       state_code,
  output logic             pa_buf_en,
  output logic             pa_en,
  output logic             mod_start,
  output logic             trig_err,
  output logic [PWR_W-1:0] pa_pwr
);
  import txs_pkg::*;

  txs_state_e state_q, ret_q;
  txs_phase_e phase_q;
  logic trig, go_off, go_pll, go_aret;
  logic pa_hit, mod_hit, idle_ok, launch;

  txs_trig_detect #(.CMD_W(CMD_W)) trig_i (
    .clk(clk), .rst(rst), .pin(slp_tx_pin), .cmd_wr(cmd_wr),
    .cmd_code(cmd_code), .trig(trig), .go_off(go_off),
    .go_pll(go_pll), .go_aret(go_aret)
  );

  assign idle_ok = (state_q == ST_PLL) || (state_q == ST_ARET);
  assign launch  = trig && idle_ok;

  txs_ramp_timer #(.PA_DLY(PA_DLY), .MOD_DLY(MOD_DLY)) timer_i (
    .clk(clk), .rst(rst), .start(launch),
    .pa_hit(pa_hit), .mod_hit(mod_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      ret_q     <= ST_OFF;
      phase_q   <= PH_RAMP;
      pa_buf_en <= 1'b0;
      pa_en     <= 1'b0;
      mod_start <= 1'b0;
      trig_err  <= 1'b0;
      pa_pwr    <= '0;
    end else begin
      mod_start <= 1'b0;
      if (state_q == ST_BUSY) begin
        if (trig) trig_err <= 1'b1;
        case (phase_q)
          PH_RAMP: begin
            if (pa_hit) pa_en <= 1'b1;
            if (mod_hit) begin
              mod_start <= 1'b1;
              phase_q   <= PH_RUN;
            end
          end
          PH_RUN: begin
            if (frame_done) begin
              pa_en   <= 1'b0;
              phase_q <= PH_DOWN;
            end
          end
          default: begin
            pa_buf_en <= 1'b0;
            state_q   <= ret_q;
            phase_q   <= PH_RAMP;
          end
        endcase
      end else begin
        pa_pwr <= pwr_in;
        if (trig) begin
          if (idle_ok) begin
            state_q   <= ST_BUSY;
            ret_q     <= state_q;
            phase_q   <= PH_RAMP;
            pa_buf_en <= 1'b1;
          end else begin
            trig_err <= 1'b1;
          end
        end else if (go_off) state_q <= ST_OFF;
        else if (go_pll)     state_q <= ST_PLL;
        else if (go_aret)    state_q <= ST_ARET;
      end
    end
  end

  assign state_code = state_q;

  p_busy_on_trig_r3: assert property (@(posedge clk) disable iff (rst)
    launch |=> state_q == ST_BUSY);
  p_pa_needs_buf_r5: assert property (@(posedge clk) disable iff (rst)
    pa_en |-> pa_buf_en);
  p_buf_leads_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pa_buf_en) |-> !pa_en);
  p_mod_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    mod_start |=> !mod_start);
  p_mod_with_pa_r6: assert property (@(posedge clk) disable iff (rst)
    mod_start |-> (pa_en && pa_buf_en));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    trig_err |=> trig_err);
  p_pa_off_first_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pa_buf_en) |-> !$past(pa_en));
  p_pwr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && $past(state_q) == ST_BUSY) |-> $stable(pa_pwr));
  p_busy_has_buf_r2: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd3) |-> pa_buf_en);
endmodule

// File: tb/txstart_seq_tb_top.sv
module txstart_seq_tb_top;
  localparam int PA  = 128;
  localparam int MOD = 256;

  typedef struct {
    int    kind;
    int    cyc;
    int    val;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slp_tx_pin = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_code = '0;
  logic [3:0] pwr_in = '0;
  logic       frame_done = 1'b0;
  logic [1:0] state_code;
  logic       pa_buf_en, pa_en, mod_start, trig_err;
  logic [3:0] pa_pwr;

  int  checks = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;
  ev_t exp_q[$];
  int  prev[4];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txstart_seq dut_i (
    .clk(clk), .rst(rst), .slp_tx_pin(slp_tx_pin), .cmd_wr(cmd_wr),
    .cmd_code(cmd_code), .pwr_in(pwr_in), .frame_done(frame_done),
    .state_code(state_code), .pa_buf_en(pa_buf_en), .pa_en(pa_en),
    .mod_start(mod_start), .trig_err(trig_err), .pa_pwr(pa_pwr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int kind, int c, int val, string req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(int kind, int val);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R7/R10 unexpected event: actual kind=%0d val=%0d cyc=%0d expected none",
               kind, val, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc || e.val != val) begin
        bad++;
        $display("FAIL %s: actual kind=%0d val=%0d cyc=%0d expected kind=%0d val=%0d cyc=%0d",
                 e.req, kind, val, cyc, e.kind, e.val, e.cyc);
      end
    end
  endtask

  // monitor: detects output changes and scores them against the queue
  always @(negedge clk) begin
    if (mon_on) begin
      int cur[4];
      cur[0] = int'(state_code);
      cur[1] = int'(pa_buf_en);
      cur[2] = int'(pa_en);
      cur[3] = int'(mod_start);
      for (int k = 0; k < 4; k++) begin
        if (cur[k] != prev[k]) pop_cmp(k, cur[k]);
        prev[k] = cur[k];
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(int code, int exp_state, string req);
    cmd_wr = 1'b1;
    cmd_code = 5'(code);
    if (exp_state >= 0) push(0, cyc + 1, exp_state, req);
    tick(1);
    cmd_wr = 1'b0;
  endtask

  task automatic expect_tx(int e, string req);
    push(0, e, 3, req);
    push(1, e, 1, "R5");
    push(2, e + PA, 1, "R5");
    push(3, e + MOD, 1, "R6");
    push(3, e + MOD + 1, 0, "R6");
  endtask

  task automatic wait_until(int c);
    while (cyc < c) tick(1);
  endtask

  task automatic finish_tx(int ret);
    int d;
    frame_done = 1'b1;
    d = cyc + 1;
    push(2, d, 0, "R8");
    push(0, d + 1, ret, "R8");
    push(1, d + 1, 0, "R8");
    tick(1);
    frame_done = 1'b0;
    tick(3);
  endtask

  initial begin
    int e;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 state", int'(state_code), 0);
    chk("R1 buf", int'(pa_buf_en), 0);
    chk("R1 pa", int'(pa_en), 0);
    chk("R1 mod", int'(mod_start), 0);
    chk("R1 err", int'(trig_err), 0);
    prev[0] = 0; prev[1] = 0; prev[2] = 0; prev[3] = 0;
    mon_on = 1'b1;

    // R2: go to locked, power follows input while idle (R9)
    send_cmd(9, 1, "R2");
    pwr_in = 4'd5;
    tick(2);
    chk("R9 pwr idle", int'(pa_pwr), 5);

    // R3: pin edge from locked; pin held high for the whole transmission
    slp_tx_pin = 1'b1;
    e = cyc + 1;
    expect_tx(e, "R3");
    tick(50);
    frame_done = 1'b1;            // R10: early frame end is ignored
    tick(1);
    frame_done = 1'b0;
    pwr_in = 4'd9;
    tick(2);
    chk("R9 pwr frozen", int'(pa_pwr), 5);
    wait_until(e + MOD + 5);
    chk("R10 pa still on", int'(pa_en), 1);
    finish_tx(1);
    tick(3);
    chk("R3 no retrigger on held pin", int'(state_code), 1);
    slp_tx_pin = 1'b0;
    chk("R9 pwr after return", int'(pa_pwr), 9);

    // R4: start command from retry-ready
    send_cmd(25, 2, "R2");
    tick(2);
    e = cyc + 1;
    expect_tx(e, "R4");
    send_cmd(2, -1, "R4");
    wait_until(e + MOD + 3);
    finish_tx(2);
    chk("R7 err clear", int'(trig_err), 0);

    // R7: start command while busy is ignored, sets error
    slp_tx_pin = 1'b1;
    e = cyc + 1;
    expect_tx(e, "R3");
    tick(10);
    slp_tx_pin = 1'b0;
    tick(5);
    send_cmd(2, -1, "R7");
    tick(1);
    chk("R7 err in busy", int'(trig_err), 1);
    wait_until(e + MOD + 3);
    finish_tx(2);

    // R7: trigger while off is ignored
    send_cmd(8, 0, "R2");
    tick(2);
    slp_tx_pin = 1'b1;
    tick(1);
    slp_tx_pin = 1'b0;
    send_cmd(2, -1, "R7");
    tick(4);
    chk("R7 off state kept", int'(state_code), 0);
    chk("R7 buf off", int'(pa_buf_en), 0);
    chk("R7 err sticky", int'(trig_err), 1);

    tick(5);
    chk("R5 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule